// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous DRAM alive on its own. After reset it stays quiet for a start-up pause. It then borrows the memory bus and issues a fixed number of CAS-before-RAS cycles. Once those are done it raises its ready flag. From then on a timer asks for one CAS-before-RAS refresh per interval, sized so that every row is refreshed inside the retention window. Refreshes that fall due while the bus is held elsewhere are counted in a small saturating counter. A tick that arrives when the counter is full sets a sticky overflow flag.

When the host raises the low-power request, the sequencer first runs a catch-up burst of refreshes over the whole row range. It then enters self refresh by holding RAS_n low, CAS-before-RAS style, for longer than the minimum entry time. It keeps RAS_n low until the request drops. On exit it waits out the long precharge, runs another full burst, and then returns to timed refresh with a fresh timer.

The bus is borrowed through a request/grant pair. The sequencer raises its request whenever it has work. It starts strobe activity only on a cycle where the grant is seen, and it keeps the request up until the closing precharge of that cycle has finished. Both CAS strobes always move together, and WE_n is never driven low.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, ras_n, cas_lo_n, cas_hi_n and we_n are 1, and bus_req, ready and pend_ovf are 0.
- R2: After reset is released, bus_req stays 0 for PAUSE_CYC cycles. The initialization phase then begins.
- R3: During initialization the sequencer issues INIT_CYCLES CAS-before-RAS cycles. ready rises on the edge that ends the last one, and it never falls afterwards.
- R4: A CAS-before-RAS cycle drives both CAS strobes low with RAS_n high for CSR_CYC cycles. It then holds RAS_n and CAS low together for RAS_LOW_CYC cycles, then holds all strobes high for PRE_CYC cycles. we_n stays 1 throughout.
- R5: A cycle starts (CAS falls on the next edge) only when bus_req and bus_grant are both 1 while the engine is idle. bus_req stays 1 until the precharge ends. While bus_req is 0 all strobes are high.
- R6: Once ready, one refresh becomes pending every REFI_CYC cycles. Each pending refresh produces exactly one CAS-before-RAS cycle when the bus is granted.
- R7: The pending count saturates at PEND_MAX. A timer tick that finds it full, with no refresh completing on that edge, sets pend_ovf, which then stays 1.
- R8: If lp_req is 1 while ready and the engine is idle, the pending count and the timer are cleared. BURST_ROWS refresh cycles follow. Then CAS falls, and RAS_n is held low for at least SELF_MIN_CYC cycles and until lp_req is 0.
- R9: When self refresh ends, all strobes stay high for SELF_PRE_CYC cycles. BURST_ROWS refresh cycles follow, after which timed refresh resumes with the timer restarted from zero.
- R10: cas_lo_n and cas_hi_n are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_req | input | 1 | Low-power request: enter and hold self refresh while 1 |
| bus_grant | input | 1 | Bus granted by the access controller |
| bus_req | output | 1 | Bus wanted or held by the sequencer |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower-byte column strobe, active low |
| cas_hi_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| ready | output | 1 | Initialization complete |
| pend_ovf | output | 1 | Sticky pending-refresh overflow |

## Verification
The strobes, request, ready and overflow are compared every cycle with a queue-based model under four patterns. A steady grant shows the basic cycle shape and the pause, initialization and timer spacing. A long grant denial makes refreshes pile up, so saturation and the sticky overflow can be seen, followed by a drain. A grant that toggles every few cycles shows that starts happen only on granted cycles and that a started cycle runs to the end whatever the grant does. A long low-power request and a short one separate a self-refresh hold set by the request from one set by the minimum hold, and each is checked with its burst on entry and on exit.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    MD_PAUSE,
    MD_INIT,
    MD_RUN,
    MD_ENTER,
    MD_LEAVE
  } seq_mode_e;

  typedef enum logic [1:0] {
    EG_IDLE,
    EG_SETUP,
    EG_LOW,
    EG_PRE
  } eng_state_e;

  function automatic int unsigned span_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned ctr_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer
  import rfs_pkg::*;
#(
  parameter int unsigned REFI_CYC = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned TW = ctr_bits(REFI_CYC);
  localparam logic [TW-1:0] LAST = TW'(REFI_CYC - 1);

  logic [TW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  generate
    if (REFI_CYC > 1) begin : g_gap
      // R6
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick)
        else $error("refresh ticks back to back");
    end
  endgenerate

endmodule

// File: rtl/rfs_pending_ctr.sv
module rfs_pending_ctr
  import rfs_pkg::*;
#(
  parameter int unsigned PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic pend_nz,
  output logic ovf
);
  localparam int unsigned PW = ctr_bits(PEND_MAX);
  localparam logic [PW-1:0] FULL = PW'(PEND_MAX);

  logic [PW-1:0] pend;
  logic          full_hit;

  assign pend_nz  = (pend != '0);
  assign full_hit = inc && !dec && !clr && (pend == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      ovf  <= 1'b0;
    end else begin
      if (full_hit) ovf <= 1'b1;
      if (clr)                               pend <= '0;
      else if (inc && !dec && pend != FULL)  pend <= pend + 1'b1;
      else if (dec && !inc)                  pend <= pend - 1'b1;
    end
  end

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf)
    else $error("overflow flag dropped");

  // R7
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) full_hit |=> pend == FULL)
    else $error("pending count left saturation on overflow");

endmodule

// File: rtl/rfs_strobe_engine.sv
module rfs_strobe_engine
  import rfs_pkg::*;
#(
  parameter int unsigned SETUP_CYC    = 2,
  parameter int unsigned LOW_CYC      = 7,
  parameter int unsigned PRE_CYC      = 4,
  parameter int unsigned HOLD_CYC     = 12600,
  parameter int unsigned HOLD_PRE_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic self_kind,
  input  logic release_ok,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int unsigned LONGEST = span_max(span_max(SETUP_CYC, LOW_CYC),
                                    span_max(span_max(PRE_CYC, HOLD_CYC), HOLD_PRE_CYC));
  localparam int unsigned CW = ctr_bits(LONGEST);
  localparam logic [CW-1:0] L_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_LOW   = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] L_PRE   = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] L_HOLD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] L_HPRE  = CW'(HOLD_PRE_CYC - 1);

  eng_state_e    st;
  logic [CW-1:0] cnt;
  logic          hold_q;
  logic          setup_end, low_end, pre_end, hold_full;

  assign hold_full = hold_q && (cnt == L_HOLD);
  assign setup_end = (cnt == L_SETUP);
  assign low_end   = hold_q ? (hold_full && release_ok) : (cnt == L_LOW);
  assign pre_end   = (cnt == (hold_q ? L_HPRE : L_PRE));

  assign busy  = (st != EG_IDLE);
  assign done  = (st == EG_PRE) && pre_end;
  assign ras_n = (st != EG_LOW);
  assign cas_n = !((st == EG_SETUP) || (st == EG_LOW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= EG_IDLE;
      cnt    <= '0;
      hold_q <= 1'b0;
    end else begin
      unique case (st)
        EG_IDLE: if (start) begin
          st     <= EG_SETUP;
          cnt    <= '0;
          hold_q <= self_kind;
        end
        EG_SETUP: if (setup_end) begin
          st  <= EG_LOW;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        EG_LOW: if (low_end) begin
          st  <= EG_PRE;
          cnt <= '0;
        end else if (!hold_full) cnt <= cnt + 1'b1;
        EG_PRE: if (pre_end) begin
          st  <= EG_IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= EG_IDLE;
      endcase
    end
  end

  // R4
  cas_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (!cas_n && $past(!cas_n)))
    else $error("RAS fell without CAS set up");

  // R4
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ras_n) |-> cas_n)
    else $error("CAS still low at RAS precharge");

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import rfs_pkg::*;
#(
  parameter int unsigned PAUSE_CYC    = 25000,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned REFI_CYC     = 1950,
  parameter int unsigned PEND_MAX     = 4,
  parameter int unsigned CSR_CYC      = 2,
  parameter int unsigned RAS_LOW_CYC  = 7,
  parameter int unsigned PRE_CYC      = 4,
  parameter int unsigned SELF_MIN_CYC = 12600,
  parameter int unsigned SELF_PRE_CYC = 12,
  parameter int unsigned BURST_ROWS   = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_req,
  input  logic bus_grant,
  output logic bus_req,
  output logic ras_n,
  output logic cas_lo_n,
  output logic cas_hi_n,
  output logic we_n,
  output logic ready,
  output logic pend_ovf
);
  localparam int unsigned PCW = ctr_bits(PAUSE_CYC);
  localparam int unsigned ICW = ctr_bits(INIT_CYCLES);
  localparam int unsigned BCW = ctr_bits(BURST_ROWS);

  seq_mode_e      mode;
  logic [PCW-1:0] pause_cnt;
  logic [ICW-1:0] init_left;
  logic [BCW-1:0] burst_left;
  logic           ready_q;

  logic want, start, self_kind, enter_now, run_mode;
  logic eng_busy, eng_done, eng_ras_n, eng_cas_n;
  logic tick, pend_nz;

  assign run_mode  = (mode == MD_RUN);
  assign enter_now = run_mode && lp_req && !eng_busy;
  assign self_kind = (mode == MD_ENTER) && (burst_left == '0);

  always_comb begin
    unique case (mode)
      MD_PAUSE: want = 1'b0;
      MD_RUN:   want = pend_nz && !lp_req;
      default:  want = 1'b1;
    endcase
  end

  assign start   = want && bus_grant && !eng_busy;
  assign bus_req = want || eng_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= MD_PAUSE;
      pause_cnt  <= '0;
      init_left  <= '0;
      burst_left <= '0;
      ready_q    <= 1'b0;
    end else begin
      unique case (mode)
        MD_PAUSE: if (pause_cnt == PCW'(PAUSE_CYC - 1)) begin
          mode      <= MD_INIT;
          init_left <= ICW'(INIT_CYCLES);
        end else pause_cnt <= pause_cnt + 1'b1;
        MD_INIT: if (eng_done) begin
          if (init_left == ICW'(1)) begin
            mode    <= MD_RUN;
            ready_q <= 1'b1;
          end else init_left <= init_left - 1'b1;
        end
        MD_RUN: if (enter_now) begin
          mode       <= MD_ENTER;
          burst_left <= BCW'(BURST_ROWS);
        end
        MD_ENTER: if (eng_done) begin
          if (burst_left == '0) begin
            mode       <= MD_LEAVE;
            burst_left <= BCW'(BURST_ROWS);
          end else burst_left <= burst_left - 1'b1;
        end
        MD_LEAVE: if (eng_done) begin
          if (burst_left == BCW'(1)) mode <= MD_RUN;
          else burst_left <= burst_left - 1'b1;
        end
        default: mode <= MD_PAUSE;
      endcase
    end
  end

  rfs_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_mode),
    .tick (tick)
  );

  rfs_pending_ctr #(.PEND_MAX(PEND_MAX)) u_pending (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!run_mode || enter_now),
    .inc    (tick),
    .dec    (eng_done && run_mode),
    .pend_nz(pend_nz),
    .ovf    (pend_ovf)
  );

  rfs_strobe_engine #(
    .SETUP_CYC   (CSR_CYC),
    .LOW_CYC     (RAS_LOW_CYC),
    .PRE_CYC     (PRE_CYC),
    .HOLD_CYC    (SELF_MIN_CYC),
    .HOLD_PRE_CYC(SELF_PRE_CYC)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .self_kind (self_kind),
    .release_ok(!lp_req),
    .busy      (eng_busy),
    .done      (eng_done),
    .ras_n     (eng_ras_n),
    .cas_n     (eng_cas_n)
  );

  assign ras_n    = eng_ras_n;
  assign cas_lo_n = eng_cas_n;
  assign cas_hi_n = eng_cas_n;
  assign we_n     = 1'b1;
  assign ready    = ready_q;

  // R5
  grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_lo_n) |-> ($past(bus_grant) && $past(bus_req)))
    else $error("strobes started without grant");

  // R5
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |-> (ras_n && cas_lo_n && cas_hi_n))
    else $error("strobe active without bus request");

  // R3
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) ready |=> ready)
    else $error("ready fell");

endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int P_PAUSE = 20;
  localparam int P_INIT  = 8;
  localparam int P_REFI  = 40;
  localparam int P_PMAX  = 3;
  localparam int P_CSR   = 2;
  localparam int P_LOW   = 3;
  localparam int P_PRE   = 2;
  localparam int P_SELF  = 30;
  localparam int P_SPRE  = 4;
  localparam int P_BURST = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic lp_req = 1'b0;
  logic bus_grant = 1'b1;
  logic bus_req, ras_n, cas_lo_n, cas_hi_n, we_n, ready, pend_ovf;

  dram_refresh_seq #(
    .PAUSE_CYC(P_PAUSE), .INIT_CYCLES(P_INIT), .REFI_CYC(P_REFI), .PEND_MAX(P_PMAX),
    .CSR_CYC(P_CSR), .RAS_LOW_CYC(P_LOW), .PRE_CYC(P_PRE), .SELF_MIN_CYC(P_SELF),
    .SELF_PRE_CYC(P_SPRE), .BURST_ROWS(P_BURST)
  ) i_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .bus_grant(bus_grant), .bus_req(bus_req),
    .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .we_n(we_n), .ready(ready),
    .pend_ovf(pend_ovf)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  // reference model: mode 0 pause, 1 init, 2 timed, 3 entering, 4 leaving
  int m_mode = 0, m_pc = 0, m_init = 0, m_pend = 0, m_tmr = 0, m_burst = 0;
  bit m_ready = 0, m_ovf = 0;
  // queue entry: bit0 ras_n, bit1 cas_n, bit2 held while lp_req
  logic [2:0] q[$];

  function automatic bit m_want();
    if (m_mode == 0) return 1'b0;
    if (m_mode == 2) return (m_pend != 0) && !lp_req;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin : model
    bit busy, pop, done, start, selfk, tick, entern;
    int old_mode;
    if (rst_n) begin
      cyc++;
      busy   = (q.size() != 0);
      pop    = busy && !(q[0][2] && lp_req);
      done   = pop && (q.size() == 1);
      start  = m_want() && bus_grant && !busy;
      selfk  = (m_mode == 3) && (m_burst == 0);
      tick   = (m_mode == 2) && (m_tmr == P_REFI - 1);
      entern = (m_mode == 2) && lp_req && !busy;
      old_mode = m_mode;
      if (pop) void'(q.pop_front());
      case (m_mode)
        0: if (m_pc == P_PAUSE - 1) begin m_mode = 1; m_init = P_INIT; end else m_pc++;
        1: if (done) begin
             if (m_init == 1) begin m_mode = 2; m_ready = 1; end else m_init--;
           end
        2: if (entern) begin m_mode = 3; m_burst = P_BURST; end
        3: if (done) begin
             if (m_burst == 0) begin m_mode = 4; m_burst = P_BURST; end else m_burst--;
           end
        4: if (done) begin
             if (m_burst == 1) m_mode = 2; else m_burst--;
           end
        default: ;
      endcase
      if (old_mode != 2 || entern) m_pend = 0;
      else if (tick && !done) begin
        if (m_pend == P_PMAX) m_ovf = 1; else m_pend++;
      end else if (done && !tick) m_pend--;
      if (old_mode == 2) m_tmr = tick ? 0 : m_tmr + 1; else m_tmr = 0;
      if (start) begin
        for (int i = 0; i < P_CSR; i++) q.push_back(3'b001);
        if (selfk) begin
          for (int i = 0; i < P_SELF - 1; i++) q.push_back(3'b000);
          q.push_back(3'b100);
          for (int i = 0; i < P_SPRE; i++) q.push_back(3'b011);
        end else begin
          for (int i = 0; i < P_LOW; i++) q.push_back(3'b000);
          for (int i = 0; i < P_PRE; i++) q.push_back(3'b011);
        end
      end
    end
  end

  always @(negedge clk) begin : compare
    logic e_ras, e_cas;
    if (rst_n && !finished) begin
      e_ras = (q.size() != 0) ? q[0][0] : 1'b1;
      e_cas = (q.size() != 0) ? q[0][1] : 1'b1;
      chk(m_mode == 3 ? "R8 ras_n" : (m_mode == 4 ? "R9 ras_n" : "R4 ras_n"), ras_n, e_ras);
      chk("R4 cas_lo_n", cas_lo_n, e_cas);
      chk("R10 cas_hi_n", cas_hi_n, cas_lo_n);
      chk("R4 we_n", we_n, 1'b1);
      chk(m_mode == 0 ? "R2 bus_req" : (m_mode == 2 ? "R6 bus_req" : "R5 bus_req"),
          bus_req, m_want() || (q.size() != 0));
      chk("R3 ready", ready, m_ready);
      chk("R7 pend_ovf", pend_ovf, m_ovf);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #20;
    // R1 reset state
    chk("R1 ras_n", ras_n, 1'b1);
    chk("R1 cas_lo_n", cas_lo_n, 1'b1);
    chk("R1 cas_hi_n", cas_hi_n, 1'b1);
    chk("R1 we_n", we_n, 1'b1);
    chk("R1 bus_req", bus_req, 1'b0);
    chk("R1 ready", ready, 1'b0);
    chk("R1 pend_ovf", pend_ovf, 1'b0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    wait_cyc(P_PAUSE - 2);
    chk("R2 quiet pause", bus_req, 1'b0);
    wait_cyc(300);
    chk("R3 ready after init", ready, 1'b1);
    bus_grant = 1'b0;
    wait_cyc(250);
    chk("R7 overflow raised", pend_ovf, 1'b1);
    for (int i = 0; i < 100; i++) begin
      bus_grant = (i % 3 == 0);
      wait_cyc(1);
    end
    bus_grant = 1'b1;
    wait_cyc(100);
    lp_req = 1'b1;
    wait_cyc(120);
    chk("R8 in self refresh", ras_n, 1'b0);
    wait_cyc(80);
    lp_req = 1'b0;
    wait_cyc(200);
    lp_req = 1'b1;
    wait_cyc(5);
    lp_req = 1'b0;
    wait_cyc(120);
    chk("R9 back to timed refresh", ras_n, 1'b1);
    for (int i = 0; i < 200; i++) begin
      bus_grant = (i % 5 != 0);
      wait_cyc(1);
    end
    summary();
  end

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

endmodule